// File: doc/BRIEF.md
# Clock-Multiplied Shared Memory with Slotted Access

This block lets logic on a slow processing clock make several independent memory accesses in each of its cycles while using only one true dual-port storage array. The array runs on a fast clock that is exactly RATIO times the slow clock (RATIO is 2 or 4), with rising edges lined up. In one slow cycle the slow side presents 2*RATIO request slots. Each slot carries an address, write data and a write enable. Over the RATIO fast edges of the following slow cycle, the block walks through the slots two at a time. It serves one slot on each port of the array.

A fast-domain phase counter, held at 0 by reset, acts as the sequencer. Its states are the phase values 0 to RATIO-1. The transition from phase p to p+1 happens on every fast edge, and the single wrap from RATIO-1 back to 0 happens on the edge that lines up with the next slow rising edge. In phase 0 the block serves the first pair from the live inputs and copies every request into holding registers. The later phases serve their pairs from those copies. Each port reads before it writes. Read results for every pair but the last are parked in fast-domain holding registers. The last pair stays in the port output registers. On the slow edge that follows, a slow-domain register gathers all the results.

A typical client is a time-multiplexed filter that fetches several coefficients per slow cycle from a table it never writes. When the two slots of one phase write the same address, the odd slot (port B) ends up in the array. Clients should treat that case as undefined.

Top module: `pumped_mem`

## Requirements
- R1: The phase counter is 0 in reset and steps 0,1,...,RATIO-1,0 on each fast edge. Phase 0 falls on the fast edge that coincides with each slow rising edge, provided reset is released within the fast period just before a slow rising edge.
- R2: There are 2*RATIO slots. Slot k uses req_addr[k*AW +: AW], req_wdata[k*DW +: DW], req_we[k] and rsp_rdata[k*DW +: DW]. req_we[k]=1 writes and 0 reads. Every slot returns the word at its address.
- R3: Requests are sampled on a slow rising edge (phase 0). Any change on the request inputs after that edge and before the next one has no effect on memory contents or responses.
- R4: The response to requests sampled on slow edge S appears on rsp_rdata just after slow edge S+1. It stays unchanged until slow edge S+2.
- R5: Reads come before writes. A writing slot returns the old contents of its address. A slot on the other port in the same phase also returns the old contents.
- R6: Slot k is served in phase k/2, with even slots on port A and odd slots on port B. A slot in a later phase sees writes made by slots of earlier phases in the same slow cycle.
- R7: While rst is high, rsp_rdata is zero. It stays zero through the first slow edge after release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_fast | input | 1 | Array clock, RATIO times clk_slow, edge-aligned |
| clk_slow | input | 1 | Client clock |
| rst | input | 1 | Synchronous reset, active high, shared by both domains |
| req_addr | input | 2*RATIO*AW | Slot addresses, slot k at bits k*AW |
| req_wdata | input | 2*RATIO*DW | Slot write data, slot k at bits k*DW |
| req_we | input | 2*RATIO | Slot write enables, bit k for slot k |
| rsp_rdata | output | 2*RATIO*DW | Slot read data, slot k at bits k*DW |

## Verification
If the phase counter is off by one, slots are served from the wrong held request. The first vector that reads and writes across phases then returns swapped or stale data on rsp_rdata within two slow cycles. A hold register that follows the live inputs instead of the phase-0 copy shows up only when the inputs move in the middle of a cycle, so the bench changes them there and reads the array back afterwards. A slip between the holding registers and the slow gather shows as a single pair of slots holding the previous cycle's data, or changing partway through a slow cycle.

// File: rtl/pm_pkg.sv
`timescale 1ns/1ps
package pm_pkg;

    localparam int PORTS_PER_ARRAY = 2;

    // first slot served in a given phase
    function automatic int unsigned lead_slot(input int unsigned phase);
        return PORTS_PER_ARRAY * phase;
    endfunction

endpackage

// File: rtl/pm_phase_ctrl.sv
`timescale 1ns/1ps
module pm_phase_ctrl #(
    parameter int RATIO = 2,
    parameter int PW    = 1
) (
    input  logic          clk_fast,
    input  logic          rst,
    output logic [PW-1:0] phase
);
    localparam logic [PW-1:0] LAST = PW'(RATIO - 1);

    always_ff @(posedge clk_fast) begin
        if (rst) begin
            phase <= '0;
        end else if (phase == LAST) begin
            phase <= '0;
        end else begin
            phase <= phase + 1'b1;
        end
    end

    assert_phase_step_R1: assert property (@(posedge clk_fast) disable iff (rst)
        (phase != LAST) |=> (phase == PW'($past(phase) + 1'b1)));

    assert_phase_wrap_R1: assert property (@(posedge clk_fast) disable iff (rst)
        (phase == LAST) |=> (phase == '0));

    assert_phase_range_R1: assert property (@(posedge clk_fast) disable iff (rst)
        int'(phase) < RATIO);

endmodule

// File: rtl/pm_req_hold.sv
`timescale 1ns/1ps
module pm_req_hold
    import pm_pkg::*;
#(
    parameter int NSLOT = 4,
    parameter int AW    = 4,
    parameter int DW    = 16,
    parameter int PW    = 1
) (
    input  logic              clk_fast,
    input  logic              rst,
    input  logic [PW-1:0]     phase,
    input  logic [NSLOT*AW-1:0] in_addr,
    input  logic [NSLOT*DW-1:0] in_wdata,
    input  logic [NSLOT-1:0]    in_we,
    output logic [AW-1:0]     a_addr,
    output logic [DW-1:0]     a_wdata,
    output logic              a_we,
    output logic [AW-1:0]     b_addr,
    output logic [DW-1:0]     b_wdata,
    output logic              b_we
);
    logic                  load;
    logic [NSLOT*AW-1:0]   addr_q;
    logic [NSLOT*DW-1:0]   wdata_q;
    logic [NSLOT-1:0]      we_q;
    logic [NSLOT*AW-1:0]   src_addr;
    logic [NSLOT*DW-1:0]   src_wdata;
    logic [NSLOT-1:0]      src_we;

    assign load = (phase == '0);

    // capture every slot on the phase-0 edge, keep it for the other phases
    always_ff @(posedge clk_fast) begin
        if (rst) begin
            addr_q  <= '0;
            wdata_q <= '0;
            we_q    <= '0;
        end else if (load) begin
            addr_q  <= in_addr;
            wdata_q <= in_wdata;
            we_q    <= in_we;
        end
    end

    always_comb begin
        int unsigned sa;
        int unsigned sb;
        src_addr  = load ? in_addr  : addr_q;
        src_wdata = load ? in_wdata : wdata_q;
        src_we    = load ? in_we    : we_q;
        sa = lead_slot(int'(phase));
        sb = sa + 1;
        a_addr  = src_addr[sa*AW +: AW];
        a_wdata = src_wdata[sa*DW +: DW];
        a_we    = src_we[sa];
        b_addr  = src_addr[sb*AW +: AW];
        b_wdata = src_wdata[sb*DW +: DW];
        b_we    = src_we[sb];
    end

    assert_req_held_R3: assert property (@(posedge clk_fast) disable iff (rst)
        (phase != '0) |=> ($stable(addr_q) && $stable(wdata_q) && $stable(we_q)));

endmodule

// File: rtl/pm_dp_array.sv
`timescale 1ns/1ps
module pm_dp_array #(
    parameter int AW = 4,
    parameter int DW = 16
) (
    input  logic          clk_fast,
    input  logic          rst,
    input  logic [AW-1:0] a_addr,
    input  logic [DW-1:0] a_wdata,
    input  logic          a_we,
    output logic [DW-1:0] a_rdata,
    input  logic [AW-1:0] b_addr,
    input  logic [DW-1:0] b_wdata,
    input  logic          b_we,
    output logic [DW-1:0] b_rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    // storage: port B is applied last, so it owns a shared address
    always_ff @(posedge clk_fast) begin
        if (a_we) begin
            mem[a_addr] <= a_wdata;
        end
        if (b_we) begin
            mem[b_addr] <= b_wdata;
        end
    end

    // output registers see the contents before this edge's writes
    always_ff @(posedge clk_fast) begin
        if (rst) begin
            a_rdata <= '0;
            b_rdata <= '0;
        end else begin
            a_rdata <= mem[a_addr];
            b_rdata <= mem[b_addr];
        end
    end

endmodule

// File: rtl/pm_rsp_regs.sv
`timescale 1ns/1ps
module pm_rsp_regs #(
    parameter int RATIO = 2,
    parameter int NSLOT = 4,
    parameter int DW    = 16,
    parameter int PW    = 1
) (
    input  logic              clk_fast,
    input  logic              clk_slow,
    input  logic              rst,
    input  logic [PW-1:0]     phase,
    input  logic [DW-1:0]     a_rdata,
    input  logic [DW-1:0]     b_rdata,
    output logic [NSLOT*DW-1:0] rsp
);
    localparam int PAIR_W = 2 * DW;
    localparam int NHOLD  = RATIO - 1;

    logic [PAIR_W-1:0]     held [NHOLD];
    logic [NSLOT*DW-1:0]   gather;

    // pair p leaves the port registers one fast edge after its phase
    for (genvar p = 0; p < NHOLD; p++) begin : g_hold
        always_ff @(posedge clk_fast) begin
            if (rst) begin
                held[p] <= '0;
            end else if (phase == PW'(p + 1)) begin
                held[p] <= {b_rdata, a_rdata};
            end
        end
        assign gather[p*PAIR_W +: PAIR_W] = held[p];
    end

    // the last pair is still in the port registers at the slow edge
    assign gather[NHOLD*PAIR_W +: PAIR_W] = {b_rdata, a_rdata};

    always_ff @(posedge clk_slow) begin
        if (rst) begin
            rsp <= '0;
        end else begin
            rsp <= gather;
        end
    end

    assert_phase_align_R1: assert property (@(posedge clk_slow) disable iff (rst)
        phase == '0);

    assert_rsp_steady_R4: assert property (@(posedge clk_fast) disable iff (rst)
        (phase != '0) |=> $stable(rsp));

endmodule

// File: rtl/pumped_mem.sv
`timescale 1ns/1ps
module pumped_mem #(
    parameter int RATIO = 2,
    parameter int AW    = 4,
    parameter int DW    = 16
) (
    input  logic                    clk_fast,
    input  logic                    clk_slow,
    input  logic                    rst,
    input  logic [2*RATIO*AW-1:0]   req_addr,
    input  logic [2*RATIO*DW-1:0]   req_wdata,
    input  logic [2*RATIO-1:0]      req_we,
    output logic [2*RATIO*DW-1:0]   rsp_rdata
);
    localparam int NSLOT = 2 * RATIO;
    localparam int PW    = (RATIO > 1) ? $clog2(RATIO) : 1;

    logic [PW-1:0] phase;
    logic [AW-1:0] a_addr, b_addr;
    logic [DW-1:0] a_wdata, b_wdata, a_rdata, b_rdata;
    logic          a_we, b_we;

    pm_phase_ctrl #(.RATIO(RATIO), .PW(PW)) u_ctrl (
        .clk_fast (clk_fast),
        .rst      (rst),
        .phase    (phase)
    );

    pm_req_hold #(.NSLOT(NSLOT), .AW(AW), .DW(DW), .PW(PW)) u_hold (
        .clk_fast (clk_fast),
        .rst      (rst),
        .phase    (phase),
        .in_addr  (req_addr),
        .in_wdata (req_wdata),
        .in_we    (req_we),
        .a_addr   (a_addr),
        .a_wdata  (a_wdata),
        .a_we     (a_we),
        .b_addr   (b_addr),
        .b_wdata  (b_wdata),
        .b_we     (b_we)
    );

    pm_dp_array #(.AW(AW), .DW(DW)) u_array (
        .clk_fast (clk_fast),
        .rst      (rst),
        .a_addr   (a_addr),
        .a_wdata  (a_wdata),
        .a_we     (a_we),
        .a_rdata  (a_rdata),
        .b_addr   (b_addr),
        .b_wdata  (b_wdata),
        .b_we     (b_we),
        .b_rdata  (b_rdata)
    );

    pm_rsp_regs #(.RATIO(RATIO), .NSLOT(NSLOT), .DW(DW), .PW(PW)) u_rsp (
        .clk_fast (clk_fast),
        .clk_slow (clk_slow),
        .rst      (rst),
        .phase    (phase),
        .a_rdata  (a_rdata),
        .b_rdata  (b_rdata),
        .rsp      (rsp_rdata)
    );

endmodule

// File: tb/pumped_mem_bench.sv
`timescale 1ns/1ps
module pumped_mem_bench;

    localparam int AW = 4;
    localparam int DW = 16;
    localparam int NV = 9;

    // {write enables slot7..0, addresses slot7..0 (nibbles), data base}
    localparam logic [55:0] VEC [NV] = '{
        {8'h00, 32'h76543210, 16'h0000},
        {8'h11, 32'h59999555, 16'h1A00},
        {8'hFF, 32'hFEDCBA98, 16'h2B00},
        {8'h26, 32'h33333333, 16'h3C00},
        {8'hA5, 32'h0C1B2A39, 16'h4D00},
        {8'h5A, 32'h88776655, 16'h5E00},
        {8'h00, 32'hFEDCBA98, 16'h0000},
        {8'hFF, 32'h76543210, 16'h6F00},
        {8'h00, 32'h01234567, 16'h0000}
    };

    logic clk_fast = 1'b0;
    logic clk_slow2 = 1'b0;
    logic clk_slow4 = 1'b0;
    logic rst = 1'b1;

    logic [4*AW-1:0] a2 = '0;
    logic [4*DW-1:0] w2 = '0;
    logic [3:0]      we2 = '0;
    logic [4*DW-1:0] rsp2;
    logic [8*AW-1:0] a4 = '0;
    logic [8*DW-1:0] w4 = '0;
    logic [7:0]      we4 = '0;
    logic [8*DW-1:0] rsp4;

    int n_chk = 0;
    int n_fail = 0;

    logic [DW-1:0] mdl [2][16];
    bit            kn  [2][16];

    initial begin
        #2.5;
        forever begin clk_fast = 1'b1; #2.5; clk_fast = 1'b0; #2.5; end
    end
    initial begin
        #2.5;
        forever begin clk_slow2 = 1'b1; #5; clk_slow2 = 1'b0; #5; end
    end
    initial begin
        #2.5;
        forever begin clk_slow4 = 1'b1; #10; clk_slow4 = 1'b0; #10; end
    end

    pumped_mem #(.RATIO(2), .AW(AW), .DW(DW)) u_pumped_mem (
        .clk_fast (clk_fast), .clk_slow (clk_slow2), .rst (rst),
        .req_addr (a2), .req_wdata (w2), .req_we (we2), .rsp_rdata (rsp2)
    );

    pumped_mem #(.RATIO(4), .AW(AW), .DW(DW)) u_pumped_mem_r4 (
        .clk_fast (clk_fast), .clk_slow (clk_slow4), .rst (rst),
        .req_addr (a4), .req_wdata (w4), .req_we (we4), .rsp_rdata (rsp4)
    );

    function automatic logic [DW-1:0] wd(input logic [DW-1:0] b, input int k);
        return b + 16'(k) * 16'h0111;
    endfunction

    function automatic logic [DW-1:0] rsp_slot(input int r, input int s);
        if (r == 2) return rsp2[s*DW +: DW];
        return rsp4[s*DW +: DW];
    endfunction

    task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wait_slow(input int r);
        if (r == 2) @(posedge clk_slow2);
        else        @(posedge clk_slow4);
    endtask

    task automatic apply(input int r, input logic [7:0] we, input logic [31:0] ad, input logic [DW-1:0] base);
        for (int k = 0; k < 2*r; k++) begin
            if (r == 2) begin
                a2[k*AW +: AW] = ad[k*4 +: 4];
                w2[k*DW +: DW] = wd(base, k);
                we2[k]         = we[k];
            end else begin
                a4[k*AW +: AW] = ad[k*4 +: 4];
                w4[k*DW +: DW] = wd(base, k);
                we4[k]         = we[k];
            end
        end
    endtask

    // expected responses by phase: both slots read first, then A writes, then B
    task automatic model_step(input int r, input logic [7:0] we, input logic [31:0] ad,
                              input logic [DW-1:0] base,
                              output logic [DW-1:0] ex [8], output bit exk [8]);
        int mi;
        mi = (r == 4) ? 1 : 0;
        for (int p = 0; p < r; p++) begin
            for (int s = 2*p; s < 2*p + 2; s++) begin
                logic [3:0] a;
                a = ad[s*4 +: 4];
                ex[s]  = mdl[mi][a];
                exk[s] = kn[mi][a];
            end
            for (int s = 2*p; s < 2*p + 2; s++) begin
                logic [3:0] a;
                a = ad[s*4 +: 4];
                if (we[s]) begin
                    mdl[mi][a] = wd(base, s);
                    kn[mi][a]  = 1'b1;
                end
            end
        end
    endtask

    task automatic run_vec(input int r, input logic [7:0] we, input logic [31:0] ad,
                           input logic [DW-1:0] base, input bit hold_chk, input string tag);
        logic [DW-1:0] ex [8];
        bit            exk [8];
        wait_slow(r); #1;
        apply(r, we, ad, base);
        model_step(r, we, ad, base, ex, exk);
        wait_slow(r); #1;            // sampled on that edge
        apply(r, 8'h00, ad, base);
        wait_slow(r); #1;            // response registered on this edge
        for (int s = 0; s < 2*r; s++) begin
            if (exk[s]) check($sformatf("%s r%0d slot%0d", tag, r, s), rsp_slot(r, s), ex[s]);
        end
        if (hold_chk) begin
            #(5*r - 3);
            for (int s = 0; s < 2*r; s++) begin
                if (exk[s]) check($sformatf("R4 held late in cycle r%0d slot%0d", r, s), rsp_slot(r, s), ex[s]);
            end
        end
    endtask

    task automatic fill(input int r);
        for (int i = 0; i < 16 / (2*r); i++) begin
            logic [31:0] ad;
            ad = '0;
            for (int k = 0; k < 2*r; k++) ad[k*4 +: 4] = 4'(i*2*r + k);
            run_vec(r, 8'hFF, ad, 16'(16'h0800 + i*16'h0040), 1'b0, "R2 fill");
        end
    endtask

    task automatic readback_all(input int r, input string tag);
        for (int i = 0; i < 16 / (2*r); i++) begin
            logic [31:0] ad;
            ad = '0;
            for (int k = 0; k < 2*r; k++) ad[k*4 +: 4] = 4'(15 - (i*2*r + k));
            run_vec(r, 8'h00, ad, 16'h0000, 1'b0, tag);
        end
    endtask

    // inputs move to conflicting writes right after the sampling edge
    task automatic late_change(input int r);
        logic [DW-1:0] ex [8];
        bit            exk [8];
        wait_slow(r); #1;
        apply(r, 8'h00, 32'h76543210, 16'h0000);
        model_step(r, 8'h00, 32'h76543210, 16'h0000, ex, exk);
        wait_slow(r); #1;
        apply(r, 8'hFF, 32'hFEDCBA98, 16'hDEAD);
        #(5*r - 3);
        apply(r, 8'h00, 32'h76543210, 16'h0000);
        wait_slow(r); #1;
        for (int s = 0; s < 2*r; s++) begin
            if (exk[s]) check($sformatf("R3 late input change r%0d slot%0d", r, s), rsp_slot(r, s), ex[s]);
        end
        readback_all(r, "R3 contents after late change");
    endtask

    initial begin
        repeat (200000) @(posedge clk_fast);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        for (int m = 0; m < 2; m++) begin
            for (int a = 0; a < 16; a++) begin
                mdl[m][a] = '0;
                kn[m][a]  = 1'b0;
            end
        end
        repeat (3) @(posedge clk_slow4);
        #1;
        check("R7 reset rsp r2 low", rsp2[31:0] ^ rsp2[63:32], 16'h0000);
        check("R7 reset rsp r2 zero", (rsp2 == '0) ? 16'h0000 : 16'h0001, 16'h0000);
        check("R7 reset rsp r4 zero", (rsp4 == '0) ? 16'h0000 : 16'h0001, 16'h0000);
        // release one fast period before a slow edge shared by both slow clocks (R1)
        @(posedge clk_slow4);
        repeat (3) @(posedge clk_fast);
        #1 rst = 1'b0;
        @(posedge clk_slow4);
        #1;
        check("R7 first edge after release r2", (rsp2 == '0) ? 16'h0000 : 16'h0001, 16'h0000);
        check("R7 first edge after release r4", (rsp4 == '0) ? 16'h0000 : 16'h0001, 16'h0000);

        for (int ri = 0; ri < 2; ri++) begin
            int r;
            r = (ri == 0) ? 2 : 4;
            fill(r);
            for (int v = 0; v < NV; v++) begin
                run_vec(r, VEC[v][55:48], VEC[v][47:16], VEC[v][15:0], v == 0,
                        $sformatf("R1 R2 R5 R6 vector%0d", v));
            end
            readback_all(r, "R2 R6 readback");
            late_change(r);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule